// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Sensing

This block is a 32-pin general-purpose I/O port on a small word-wide register bus. Software chooses a direction for each pin, drives output values and samples the pins. Output bits can be changed atomically: one register ORs ones into the output word and another ANDs them out, so no read-modify-write is needed.

Each pin can also raise an interrupt. Its trigger is chosen by three configuration bits: a sense-type bit (edge or level), a polarity bit and an any-edge bit. Pins pass through a two-flop synchroniser before detection. Every enabled pin records a sticky status bit, and software clears it by writing ones. The raw status word comes out on its own port. A single port-wide interrupt line is the OR of all status bits whose mask bit is zero.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, these are all zero: the output word, direction, interrupt enable, mask, sense-type, any-edge, polarity and status. The pin_oe, pin_out, irq_raw and irq_out ports are also zero.
- R2: pin_oe bit i is the direction bit i, at word offset 0x08 (1 = output, 0 = input). pin_out is the output word at offset 0x00, which reads back unchanged.
- R3: A write to offset 0x10 sets every output bit where the written word has a 1. A write to offset 0x14 clears every output bit where the written word has a 1. Bits written as zero keep their value in both cases.
- R4: A read of offset 0x04 returns the pins after the two-flop synchroniser.
- R5: With sense-type 0 (offset 0x34) and any-edge 0 (offset 0x38), a polarity bit of 0 (offset 0x3C) records a 0-to-1 change of the pin and a polarity bit of 1 records a 1-to-0 change.
- R6: With sense-type 0 and any-edge 1, a change in either direction is recorded and the polarity bit has no effect. A pin that does not change records nothing.
- R7: With sense-type 1, status is set on every cycle the pin is high (polarity 0) or low (polarity 1), and any-edge has no effect. Level status stays set after the pin goes inactive until software clears it.
- R8: A pin with interrupt enable 0 (offset 0x20) never sets its status bit.
- R9: Writing to offset 0x30 clears the status bits where the written word has a 1 and leaves the other status bits set. An active level sets its bit again on the next cycle.
- R10: Status reads at offset 0x24 and appears on irq_raw. irq_out is high, one cycle after the status register, when any status bit has mask bit (offset 0x2C) 0. A set mask bit hides its pin from irq_out but not from status.
- R11: Offsets 0x18, 0x1C, 0x40 and 0x44 are read/write words with no function. Reads of any other unmapped offset, for example 0x28 or 0x48, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the word register |
| bus_wdata | input | N_PINS (32) | Write data |
| bus_rdata | output | N_PINS (32) | Read data, registered, valid the cycle after a read strobe |
| pin_in | input | N_PINS (32) | Asynchronous pin inputs |
| pin_out | output | N_PINS (32) | Output data word |
| pin_oe | output | N_PINS (32) | Per-pin output enable |
| irq_raw | output | N_PINS (32) | Sticky interrupt status word |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that a write strobe lasts exactly one cycle and carries its address and data in that same cycle. They also assume that reset is applied before the first checked cycle, since the status and output checks compare against the previous cycle's bus values. The stimulus makes bus accesses one at a time and changes pins only on the falling clock edge. It holds every pin level long enough for the synchroniser and the previous-sample flop to settle before the next change, so each edge test sees exactly one transition.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [7:0] OFS_DOUT   = 8'h00;
  localparam logic [7:0] OFS_DIN    = 8'h04;
  localparam logic [7:0] OFS_DIR    = 8'h08;
  localparam logic [7:0] OFS_OSET   = 8'h10;
  localparam logic [7:0] OFS_OCLR   = 8'h14;
  localparam logic [7:0] OFS_SPARE0 = 8'h18;
  localparam logic [7:0] OFS_SPARE1 = 8'h1C;
  localparam logic [7:0] OFS_IEN    = 8'h20;
  localparam logic [7:0] OFS_ISTAT  = 8'h24;
  localparam logic [7:0] OFS_IMASK  = 8'h2C;
  localparam logic [7:0] OFS_IACK   = 8'h30;
  localparam logic [7:0] OFS_SENSE  = 8'h34;
  localparam logic [7:0] OFS_ANYEDG = 8'h38;
  localparam logic [7:0] OFS_POLAR  = 8'h3C;
  localparam logic [7:0] OFS_SPARE2 = 8'h40;
  localparam logic [7:0] OFS_SPARE3 = 8'h44;

  typedef enum logic [1:0] {
    DET_RISE,
    DET_FALL,
    DET_ANY,
    DET_LEVEL
  } det_kind_e;

  function automatic det_kind_e det_kind(input logic sense, input logic anyedg,
                                         input logic polar);
    if (sense) return DET_LEVEL;
    if (anyedg) return DET_ANY;
    return polar ? DET_FALL : DET_RISE;
  endfunction

  function automatic logic det_hit(input det_kind_e k, input logic polar,
                                   input logic cur, input logic prev);
    case (k)
      DET_RISE:  return cur & ~prev;
      DET_FALL:  return prev & ~cur;
      DET_ANY:   return cur ^ prev;
      default:   return cur ^ polar;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic en,
  input  logic sense,
  input  logic anyedg,
  input  logic polar,
  input  logic ack,
  output logic stat
);
  logic      prev_q;
  det_kind_e kind;
  logic      hit;

  always_comb begin
    kind = det_kind(sense, anyedg, polar);
    hit  = en & det_hit(kind, polar, cur, prev_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat   <= 1'b0;
    end else begin
      prev_q <= cur;
      if (hit)
        stat <= 1'b1;
      else if (ack)
        stat <= 1'b0;
    end
  end

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !stat) |=> !stat);

  // R9
  fall_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat) |-> $past(ack));

  // R7
  level_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sense && (cur != polar)) |=> stat);
endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pins_sync,
  input  logic [N_PINS-1:0] stat,
  output logic [N_PINS-1:0] dout_q,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] ien_q,
  output logic [N_PINS-1:0] imask_q,
  output logic [N_PINS-1:0] sense_q,
  output logic [N_PINS-1:0] anyedg_q,
  output logic [N_PINS-1:0] polar_q,
  output logic [N_PINS-1:0] ack_pulse
);
  localparam int NSPARE = 4;

  logic                   wr_en;
  logic                   rd_en;
  logic [N_PINS-1:0]      spare_q [NSPARE];
  logic [ADDR_W-1:0]      spare_ofs [NSPARE];
  logic [N_PINS-1:0]      rd_mux;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  function automatic logic hit_ofs(input logic [ADDR_W-1:0] a, input logic [7:0] o);
    return a == ADDR_W'(o);
  endfunction

  assign ack_pulse = (wr_en && hit_ofs(bus_addr, OFS_IACK)) ? bus_wdata : '0;

  always_comb begin
    spare_ofs[0] = ADDR_W'(OFS_SPARE0);
    spare_ofs[1] = ADDR_W'(OFS_SPARE1);
    spare_ofs[2] = ADDR_W'(OFS_SPARE2);
    spare_ofs[3] = ADDR_W'(OFS_SPARE3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dir_q    <= '0;
      ien_q    <= '0;
      imask_q  <= '0;
      sense_q  <= '0;
      anyedg_q <= '0;
      polar_q  <= '0;
    end else if (wr_en) begin
      if (hit_ofs(bus_addr, OFS_DOUT))   dout_q   <= bus_wdata;
      if (hit_ofs(bus_addr, OFS_OSET))   dout_q   <= dout_q | bus_wdata;
      if (hit_ofs(bus_addr, OFS_OCLR))   dout_q   <= dout_q & ~bus_wdata;
      if (hit_ofs(bus_addr, OFS_DIR))    dir_q    <= bus_wdata;
      if (hit_ofs(bus_addr, OFS_IEN))    ien_q    <= bus_wdata;
      if (hit_ofs(bus_addr, OFS_IMASK))  imask_q  <= bus_wdata;
      if (hit_ofs(bus_addr, OFS_SENSE))  sense_q  <= bus_wdata;
      if (hit_ofs(bus_addr, OFS_ANYEDG)) anyedg_q <= bus_wdata;
      if (hit_ofs(bus_addr, OFS_POLAR))  polar_q  <= bus_wdata;
    end
  end

  for (genvar s = 0; s < NSPARE; s++) begin : g_spare
    always_ff @(posedge clk) begin
      if (rst)
        spare_q[s] <= '0;
      else if (wr_en && bus_addr == spare_ofs[s])
        spare_q[s] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ofs(bus_addr, OFS_DOUT))   rd_mux = dout_q;
    if (hit_ofs(bus_addr, OFS_DIN))    rd_mux = pins_sync;
    if (hit_ofs(bus_addr, OFS_DIR))    rd_mux = dir_q;
    if (hit_ofs(bus_addr, OFS_IEN))    rd_mux = ien_q;
    if (hit_ofs(bus_addr, OFS_ISTAT))  rd_mux = stat;
    if (hit_ofs(bus_addr, OFS_IMASK))  rd_mux = imask_q;
    if (hit_ofs(bus_addr, OFS_SENSE))  rd_mux = sense_q;
    if (hit_ofs(bus_addr, OFS_ANYEDG)) rd_mux = anyedg_q;
    if (hit_ofs(bus_addr, OFS_POLAR))  rd_mux = polar_q;
    for (int s = 0; s < NSPARE; s++)
      if (bus_addr == spare_ofs[s]) rd_mux = spare_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_en)
      bus_rdata <= rd_mux;
  end

  // R3
  oset_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_ofs(bus_addr, OFS_OSET)) |=>
      ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  oclr_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_ofs(bus_addr, OFS_OCLR)) |=> ((dout_q & $past(bus_wdata)) == '0));

  // R3
  oset_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_ofs(bus_addr, OFS_OSET)) |=>
      ((dout_q & ~$past(bus_wdata)) == ($past(dout_q) & ~$past(bus_wdata))));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] irq_raw,
  output logic              irq_out
);
  logic [N_PINS-1:0] pins_sync;
  logic [N_PINS-1:0] stat;
  logic [N_PINS-1:0] dout_q, dir_q, ien_q, imask_q;
  logic [N_PINS-1:0] sense_q, anyedg_q, polar_q, ack_pulse;
  logic              irq_q;

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_sync)
  );

  gpio_csr #(.ADDR_W(ADDR_W), .N_PINS(N_PINS)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_sync (pins_sync),
    .stat      (stat),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .imask_q   (imask_q),
    .sense_q   (sense_q),
    .anyedg_q  (anyedg_q),
    .polar_q   (polar_q),
    .ack_pulse (ack_pulse)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_trig_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .cur    (pins_sync[i]),
      .en     (ien_q[i]),
      .sense  (sense_q[i]),
      .anyedg (anyedg_q[i]),
      .polar  (polar_q[i]),
      .ack    (ack_pulse[i]),
      .stat   (stat[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= |(stat & ~imask_q);
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq_raw = stat;
  assign irq_out = irq_q;

  // R10
  irq_needs_stat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|stat));

  // R10
  irq_all_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (&imask_q) |=> !irq_out);
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int AW = 8;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, irq_raw;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] rd;

  always #4 clk = ~clk;

  gpio_port #(.ADDR_W(AW), .N_PINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_raw(irq_raw), .irq_out(irq_out)
  );

  // fields: [5] sense, [4] any-edge, [3] polarity, [2] start level, [1] end level, [0] expected
  localparam logic [5:0] VEC [0:13] = '{
    6'b000_01_1, 6'b000_10_0, 6'b001_10_1, 6'b001_01_0,
    6'b010_01_1, 6'b010_10_1, 6'b011_11_0,
    6'b100_01_1, 6'b100_00_0, 6'b100_10_1,
    6'b101_10_1, 6'b101_11_0,
    6'b110_00_0, 6'b110_01_1
  };

  task automatic chk(input string req, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdw(input logic [7:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq_raw", irq_raw, '0);
    chk("R1 irq_out", {31'd0, irq_out}, '0);
    rdw(8'h20, rd); chk("R1 enable", rd, '0);
    rdw(8'h34, rd); chk("R1 sense", rd, '0);
    rdw(8'h2C, rd); chk("R1 mask", rd, '0);

    // vector table walk: R5 R6 R7
    for (int i = 0; i < 14; i++) begin
      int p;
      logic [5:0] v;
      p = (i * 5 + 1) % NP;
      v = VEC[i];
      wr(8'h20, '0);
      wr(8'h30, '1);
      wr(8'h34, NP'(v[5]) << p);
      wr(8'h38, NP'(v[4]) << p);
      wr(8'h3C, NP'(v[3]) << p);
      @(negedge clk); pin_in = NP'(v[2]) << p;
      cyc(4);
      wr(8'h20, NP'(1) << p);
      wr(8'h30, '1);
      @(negedge clk); pin_in = NP'(v[1]) << p;
      cyc(5);
      chk($sformatf("R5/R6/R7 vec%0d status", i), irq_raw, NP'(v[0]) << p);
      chk($sformatf("R10 vec%0d irq", i), {31'd0, irq_out}, {31'd0, v[0]});
    end

    // clean slate
    wr(8'h20, '0); wr(8'h34, '0); wr(8'h38, '0); wr(8'h3C, '0);
    @(negedge clk); pin_in = '0; cyc(4); wr(8'h30, '1);

    // R2 direction and output word
    wr(8'h08, 32'h8000_00F1);
    chk("R2 pin_oe", pin_oe, 32'h8000_00F1);
    wr(8'h00, 32'h0000_0F0F);
    chk("R2 pin_out", pin_out, 32'h0000_0F0F);
    rdw(8'h00, rd); chk("R2 readback", rd, 32'h0000_0F0F);

    // R3 atomic set and clear
    wr(8'h10, 32'hF000_0000);
    chk("R3 set", pin_out, 32'hF000_0F0F);
    wr(8'h14, 32'h0000_0F01);
    chk("R3 clear", pin_out, 32'hF000_000E);

    // R4 synchronised input
    @(negedge clk); pin_in = 32'hA5A5_0000;
    cyc(3);
    rdw(8'h04, rd); chk("R4 input", rd, 32'hA5A5_0000);
    @(negedge clk); pin_in = '0; cyc(4);

    // R8 enable gating
    @(negedge clk); pin_in = 32'h0000_0010;
    cyc(5);
    chk("R8 disabled pin", irq_raw, '0);
    @(negedge clk); pin_in = '0; cyc(4);

    // R9 partial ack; R10 mask
    wr(8'h20, 32'h0000_0088);
    wr(8'h2C, 32'h0000_0088);
    @(negedge clk); pin_in = 32'h0000_0088;
    cyc(5);
    chk("R10 masked status kept", irq_raw, 32'h0000_0088);
    chk("R10 masked irq low", {31'd0, irq_out}, '0);
    rdw(8'h24, rd); chk("R10 status read", rd, 32'h0000_0088);
    wr(8'h2C, 32'h0000_0008);
    cyc(1);
    chk("R10 unmasked irq", {31'd0, irq_out}, 32'd1);
    wr(8'h30, 32'h0000_0080);
    chk("R9 partial ack", irq_raw, 32'h0000_0008);
    cyc(1);
    chk("R10 irq after ack", {31'd0, irq_out}, '0);
    wr(8'h30, '1);
    chk("R9 ack all", irq_raw, '0);

    // R9 level reassert after ack
    wr(8'h34, 32'h0000_0200);
    wr(8'h20, 32'h0000_0200);
    @(negedge clk); pin_in = 32'h0000_0200;
    cyc(4);
    wr(8'h30, '1);
    cyc(1);
    chk("R9 level reasserts", irq_raw, 32'h0000_0200);

    // R11 spare storage and unmapped reads
    wr(8'h18, 32'h1234_5678); wr(8'h1C, 32'h0BAD_F00D);
    wr(8'h40, 32'hCAFE_0001); wr(8'h44, 32'h0000_00FF);
    rdw(8'h18, rd); chk("R11 spare0", rd, 32'h1234_5678);
    rdw(8'h1C, rd); chk("R11 spare1", rd, 32'h0BAD_F00D);
    rdw(8'h40, rd); chk("R11 spare2", rd, 32'hCAFE_0001);
    rdw(8'h44, rd); chk("R11 spare3", rd, 32'h0000_00FF);
    wr(8'h28, '1);
    rdw(8'h28, rd); chk("R11 unmapped 0x28", rd, '0);
    rdw(8'h48, rd); chk("R11 unmapped 0x48", rd, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule